// File: doc/BRIEF.md
# Static Memory Read Strobe Timer

This block runs the read cycles of an asynchronous static memory bus. A requester presents a chip-select index and a 24-bit address. The block then drives the address onto the bus and shapes two active-low strobes from a cycle counter: one for the addressed chip select and one for read enable. Each strobe has its own programmable delay and width. A separate programmable total length decides when the address may change and when the next request can be taken. The low time left after each strobe's pulse is not programmed. It is whatever remains of the total length.

Each chip select has its own set of five timing fields, all counted in clock cycles. They are written through a small register port. When a request is accepted, the fields of that chip select are copied, so a later write never changes a cycle that is already running. The 8-bit read data is latched on the clock edge where the read strobe goes high again. It appears on `rdata_o` with a one-cycle `done_o` pulse. If a strobe's delay plus width is larger than the total length, the strobe is cut off at the end of the cycle and `err_o` is raised for that cycle.

Top module: `ext_rd_timer`

## Requirements
- R1: A write on the register port (`cfg_we_i` high) stores `cfg_wdata_i` into one field of the timing set of chip select `cfg_cs_i`. The field codes are: 0 read delay, 1 read width, 2 chip-select delay, 3 chip-select width, 4 total length. Codes 5 to 7 are ignored. A read uses the values held when its request was accepted; writes made during a running cycle take effect from the next request on.
- R2: A request (`req_i` high while `busy_o` is low) is accepted at the clock edge. From the next cycle on, `busy_o` is high for exactly the total length in cycles, and `mem_addr_o` holds the request address the whole time. Requests seen while `busy_o` is high are ignored.
- R3: `mem_rd_n_o` goes low in the cycle whose offset from the first busy cycle (offset 0) equals the read delay. It stays low for the read width in cycles. A width of 0 gives no pulse.
- R4: Only the addressed bit of `mem_cs_n_o` goes low, starting at offset equal to the chip-select delay and lasting for the chip-select width. All other bits stay high.
- R5: Neither strobe is low outside the busy window. A pulse that would run past the total length is cut short at the last busy cycle. A delay of at least the total length gives no pulse.
- R6: `mem_data_i` is latched into `rdata_o` at the edge that ends the last low cycle of `mem_rd_n_o`. `done_o` is high for exactly the one cycle that follows that edge.
- R7: If the read strobe never goes low in a cycle, `done_o` pulses once, in the cycle right after the last busy cycle, and `rdata_o` keeps its previous value.
- R8: At acceptance, `err_o` is set to 1 if read delay plus read width, or chip-select delay plus chip-select width, is larger than the total length; otherwise it is set to 0. It keeps that value until the next request is accepted.
- R9: After reset, `busy_o`, `done_o` and `err_o` are 0, `rdata_o` is 0, and all strobes are high. Every chip select starts with delays of 1, widths of 2 and a total length of 4.
- R10: A total length of 0 behaves as a total length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all timing counts are in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register port write strobe |
| cfg_cs_i | input | 2 | Chip select whose timing set is written |
| cfg_fld_i | input | 3 | Field code (see R1) |
| cfg_wdata_i | input | 6 | Value written to the field |
| req_i | input | 1 | Read request |
| req_cs_i | input | 2 | Chip select index of the request |
| req_addr_i | input | 24 | Address of the request |
| busy_o | output | 1 | High while a read cycle runs |
| mem_addr_o | output | 24 | Address bus |
| mem_cs_n_o | output | 4 | Active-low chip-select strobes, one per chip select |
| mem_rd_n_o | output | 1 | Active-low read-enable strobe |
| mem_data_i | input | 8 | Data bus from the memory |
| rdata_o | output | 8 | Latched read data |
| done_o | output | 1 | One-cycle pulse when read data is latched |
| err_o | output | 1 | Timing overflow flag for the current or last cycle |

## Verification
The hardest case to reach from the ports is showing that the latch happens at the right edge. An edge that is one cycle early or late would still catch plausible data. To expose this, the bench's memory model returns the address low byte plus the number of clock cycles the read strobe has been low so far. The latched value therefore encodes the exact edge. Cut-off pulses, missing pulses and a total length of 0 all come from the vector table. A register write issued in the middle of a cycle is checked by comparing that cycle's length against the length of the one that follows.

// File: rtl/ext_rd_pkg.sv
package ext_rd_pkg;
  localparam int unsigned CNT_W = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t rd_setup;
    cnt_t rd_pulse;
    cnt_t cs_setup;
    cnt_t cs_pulse;
    cnt_t total;
  } rd_timing_t;

  typedef enum logic [2:0] {
    FLD_RD_SETUP = 3'd0,
    FLD_RD_PULSE = 3'd1,
    FLD_CS_SETUP = 3'd2,
    FLD_CS_PULSE = 3'd3,
    FLD_TOTAL    = 3'd4
  } cfg_fld_e;

  localparam rd_timing_t TIMING_RST = '{
    rd_setup: cnt_t'(1),
    rd_pulse: cnt_t'(2),
    cs_setup: cnt_t'(1),
    cs_pulse: cnt_t'(2),
    total:    cnt_t'(4)
  };
endpackage

// File: rtl/ext_rd_cfg.sv
module ext_rd_cfg
  import ext_rd_pkg::*;
#(
  parameter int unsigned N_CS = 4,
  parameter int unsigned CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic [2:0]      fld_i,
  input  cnt_t            wdata_i,
  input  logic [CS_W-1:0] rd_cs_i,
  output rd_timing_t      timing_o
);
  rd_timing_t tbl_q [N_CS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CS; i++) tbl_q[i] <= TIMING_RST;
    end else if (we_i) begin
      for (int i = 0; i < N_CS; i++) begin
        if (cs_i == CS_W'(i)) begin
          case (fld_i)
            FLD_RD_SETUP: tbl_q[i].rd_setup <= wdata_i;
            FLD_RD_PULSE: tbl_q[i].rd_pulse <= wdata_i;
            FLD_CS_SETUP: tbl_q[i].cs_setup <= wdata_i;
            FLD_CS_PULSE: tbl_q[i].cs_pulse <= wdata_i;
            FLD_TOTAL:    tbl_q[i].total    <= wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  assign timing_o = tbl_q[rd_cs_i];
endmodule

// File: rtl/ext_rd_strobe.sv
module ext_rd_strobe
  import ext_rd_pkg::*;
(
  input  logic active_i,
  input  logic last_i,
  input  cnt_t cnt_i,
  input  cnt_t setup_i,
  input  cnt_t pulse_i,
  output logic low_o,
  output logic rise_o
);
  logic [CNT_W:0] end_w;
  logic [CNT_W:0] nxt_w;

  assign end_w  = {1'b0, setup_i} + {1'b0, pulse_i};
  assign nxt_w  = {1'b0, cnt_i} + 1'b1;
  assign low_o  = active_i && (cnt_i >= setup_i) && ({1'b0, cnt_i} < end_w);
  // strobe returns high at the coming edge: window end or forced by cycle end
  assign rise_o = low_o && ((nxt_w == end_w) || last_i);
endmodule

// File: rtl/ext_rd_seq.sv
module ext_rd_seq
  import ext_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  rd_timing_t        timing_i,
  output logic              busy_o,
  output logic              last_o,
  output cnt_t              cnt_o,
  output rd_timing_t        tim_o,
  output logic [CS_W-1:0]   cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o
);
  logic              busy_q, err_q, start;
  cnt_t              cnt_q;
  rd_timing_t        tim_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W:0]    rd_sum, cs_sum;
  logic              ovf;

  assign start  = req_i && !busy_q;
  assign rd_sum = {1'b0, timing_i.rd_setup} + {1'b0, timing_i.rd_pulse};
  assign cs_sum = {1'b0, timing_i.cs_setup} + {1'b0, timing_i.cs_pulse};
  assign ovf    = (rd_sum > {1'b0, timing_i.total}) || (cs_sum > {1'b0, timing_i.total});
  // total of 0 ends after the first cycle, same as 1
  assign last_o = busy_q && (({1'b0, cnt_q} + 1'b1) >= {1'b0, tim_q.total});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      tim_q  <= '0;
      cs_q   <= '0;
      addr_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tim_q  <= timing_i;
      cs_q   <= req_cs_i;
      addr_q <= req_addr_i;
      err_q  <= ovf;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign tim_o  = tim_q;
  assign cs_o   = cs_q;
  assign addr_o = addr_q;
  assign err_o  = err_q;

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> $stable(addr_q)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q); // R2
  AST_TIM_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(tim_q)); // R1
  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(err_q)); // R8
endmodule

// File: rtl/ext_rd_timer.sv
module ext_rd_timer
  import ext_rd_pkg::*;
#(
  parameter int unsigned N_CS   = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CS_W  = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CS_W-1:0]   cfg_cs_i,
  input  logic [2:0]        cfg_fld_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  input  logic              req_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [N_CS-1:0]   mem_cs_n_o,
  output logic              mem_rd_n_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o
);
  rd_timing_t      cfg_tim, cur_tim;
  logic            busy, last;
  cnt_t            cnt;
  logic [CS_W-1:0] cur_cs;
  logic            rd_low, rd_rise, cs_low, cs_rise;
  logic            rd_seen_q, done_q;
  logic [DATA_W-1:0] rdata_q;

  ext_rd_cfg #(.N_CS(N_CS), .CS_W(CS_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .cs_i(cfg_cs_i), .fld_i(cfg_fld_i), .wdata_i(cfg_wdata_i),
    .rd_cs_i(req_cs_i), .timing_o(cfg_tim)
  );

  ext_rd_seq #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_seq (
    .clk_i, .rst_ni,
    .req_i, .req_cs_i, .req_addr_i, .timing_i(cfg_tim),
    .busy_o(busy), .last_o(last), .cnt_o(cnt), .tim_o(cur_tim),
    .cs_o(cur_cs), .addr_o(mem_addr_o), .err_o(err_o)
  );

  ext_rd_strobe u_rd_stb (
    .active_i(busy), .last_i(last), .cnt_i(cnt),
    .setup_i(cur_tim.rd_setup), .pulse_i(cur_tim.rd_pulse),
    .low_o(rd_low), .rise_o(rd_rise)
  );

  ext_rd_strobe u_cs_stb (
    .active_i(busy), .last_i(last), .cnt_i(cnt),
    .setup_i(cur_tim.cs_setup), .pulse_i(cur_tim.cs_pulse),
    .low_o(cs_low), .rise_o(cs_rise)
  );

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign mem_cs_n_o[g] = !(cs_low && (cur_cs == CS_W'(g)));
  end

  assign mem_rd_n_o = !rd_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      done_q    <= 1'b0;
      rd_seen_q <= 1'b0;
    end else begin
      if (rd_rise) rdata_q <= mem_data_i;
      // no strobe this cycle: still complete at cycle end
      done_q    <= rd_rise || (last && !rd_seen_q && !rd_low);
      rd_seen_q <= busy && !last && (rd_seen_q || rd_low);
    end
  end

  assign busy_o  = busy;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_n_o)); // R4
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> mem_rd_n_o && (&mem_cs_n_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rise |=> $stable(rdata_q)); // R7
  AST_CS_RISE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (&mem_cs_n_o)); // R4
endmodule

// File: tb/ext_rd_timer_tb_top.sv
module ext_rd_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  cs;
    logic [23:0] addr;
    logic [5:0]  rs, rp, ss, sp, cyc;
  } vec_t;

  // cs, addr, rd delay, rd width, cs delay, cs width, total
  localparam vec_t VECS [8] = '{
    '{2'd0, 24'h123456, 6'd1, 6'd2, 6'd0, 6'd4, 6'd5},
    '{2'd1, 24'hABCDEF, 6'd0, 6'd1, 6'd0, 6'd1, 6'd1},
    '{2'd2, 24'h00F00D, 6'd3, 6'd5, 6'd1, 6'd2, 6'd6},
    '{2'd3, 24'h777701, 6'd2, 6'd0, 6'd1, 6'd3, 6'd4},
    '{2'd1, 24'h3C3C3C, 6'd0, 6'd3, 6'd2, 6'd9, 6'd7},
    '{2'd0, 24'h0000A0, 6'd7, 6'd2, 6'd0, 6'd0, 6'd5},
    '{2'd2, 24'hFFFF10, 6'd4, 6'd4, 6'd3, 6'd6, 6'd0},
    '{2'd3, 24'h246802, 6'd2, 6'd3, 6'd1, 6'd5, 6'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_cs = '0;
  logic [2:0]  cfg_fld = '0;
  logic [5:0]  cfg_wdata = '0;
  logic        req = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic        busy;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_rd_n;
  logic [7:0]  mem_data;
  logic [7:0]  rdata;
  logic        done;
  logic        err;
  logic [7:0]  low_cnt = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: value encodes how many cycles the read strobe has been low
  assign mem_data = mem_addr[7:0] + low_cnt;

  ext_rd_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_cs_i(cfg_cs), .cfg_fld_i(cfg_fld), .cfg_wdata_i(cfg_wdata),
    .req_i(req), .req_cs_i(req_cs), .req_addr_i(req_addr),
    .busy_o(busy), .mem_addr_o(mem_addr), .mem_cs_n_o(mem_cs_n), .mem_rd_n_o(mem_rd_n),
    .mem_data_i(mem_data), .rdata_o(rdata), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] cs, input int fld, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = cs; cfg_fld = 3'(fld); cfg_wdata = 6'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_all(input logic [1:0] cs, input int rs, rp, ss, sp, cyc);
    wr(cs, 0, rs); wr(cs, 1, rp); wr(cs, 2, ss); wr(cs, 3, sp); wr(cs, 4, cyc);
  endtask

  // hold: keep requesting with another address while busy; poke: rewrite total mid-cycle
  task automatic do_read(input logic [1:0] cs, input logic [23:0] addr,
                         input int rs, rp, ss, sp, cyc, input bit hold, input bit poke);
    int cye, rd_len, cs_len, exp_done, exp_err;
    int busy_n, rd_first, rd_n, cs_first, cs_n, done_idx, done_n, addr_bad, other_bad, err_late;
    logic [7:0] rd_at_done;
    cye = (cyc == 0) ? 1 : cyc;
    rd_len = (rs >= cye) ? 0 : (((rs + rp) < cye ? (rs + rp) : cye) - rs);
    cs_len = (ss >= cye) ? 0 : (((ss + sp) < cye ? (ss + sp) : cye) - ss);
    exp_done = (rd_len > 0) ? rs + rd_len : cye;
    exp_err = ((rs + rp) > cyc || (ss + sp) > cyc) ? 1 : 0;
    busy_n = 0; rd_first = -1; rd_n = 0; cs_first = -1; cs_n = 0;
    done_idx = -1; done_n = 0; addr_bad = 0; other_bad = 0; err_late = 0; rd_at_done = '0;
    @(negedge clk);
    req = 1'b1; req_cs = cs; req_addr = addr; low_cnt = '0;
    for (int k = 0; k < cye + 2; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (hold) req_addr = ~addr; else req = 1'b0;
        chk(err == 1'(exp_err), "R8", "err at start", int'(err), exp_err);
      end
      if (hold && k == cye - 1) req = 1'b0;
      if (poke && k == 1) begin
        cfg_we = 1'b1; cfg_cs = cs; cfg_fld = 3'd4; cfg_wdata = 6'd2;
      end
      if (poke && k == 2) cfg_we = 1'b0;
      if (busy) begin
        busy_n++;
        if (mem_addr != addr) addr_bad++;
      end
      if (!mem_rd_n) begin
        if (rd_first < 0) rd_first = k;
        rd_n++;
        low_cnt = low_cnt + 8'd1;
      end
      if (!mem_cs_n[cs]) begin
        if (cs_first < 0) cs_first = k;
        cs_n++;
      end
      if ((~mem_cs_n & ~(4'b1 << cs)) != 4'b0) other_bad++;
      if (done) begin
        if (done_idx < 0) done_idx = k;
        done_n++;
        rd_at_done = rdata;
      end
      if (k == cye + 1) err_late = int'(err);
    end
    if (rd_len > 0) exp_rdata = addr[7:0] + 8'(rd_len);
    chk(busy_n == cye, (cyc == 0) ? "R10" : "R2", "busy cycles", busy_n, cye);
    chk(addr_bad == 0, "R2", "address changes while busy", addr_bad, 0);
    chk(rd_n == rd_len, ((rs + rp) > cye) ? "R5" : "R3", "read strobe width", rd_n, rd_len);
    if (rd_len > 0) chk(rd_first == rs, "R3", "read strobe offset", rd_first, rs);
    chk(cs_n == cs_len, ((ss + sp) > cye) ? "R5" : "R4", "cs strobe width", cs_n, cs_len);
    if (cs_len > 0) chk(cs_first == ss, "R4", "cs strobe offset", cs_first, ss);
    chk(other_bad == 0, "R4", "unselected cs low", other_bad, 0);
    chk(done_n == 1, "R6", "done pulses", done_n, 1);
    chk(done_idx == exp_done, (rd_len > 0) ? "R6" : "R7", "done position", done_idx, exp_done);
    chk(rd_at_done == exp_rdata, (rd_len > 0) ? "R6" : "R7", "read data", int'(rd_at_done), int'(exp_rdata));
    chk(err_late == exp_err, "R8", "err held after cycle", err_late, exp_err);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R9", "flags in reset",
        int'({busy, done, err}), 0);
    chk(mem_rd_n == 1'b1 && mem_cs_n == 4'hF, "R9", "strobes in reset",
        int'({mem_rd_n, mem_cs_n}), 31);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h00 && busy == 1'b0, "R9", "idle after reset", int'(rdata), 0);
    // R9 reset timing defaults on cs0 and cs3
    do_read(2'd0, 24'h0000C1, 1, 2, 1, 2, 4, 1'b0, 1'b0);
    do_read(2'd3, 24'h5A5A11, 1, 2, 1, 2, 4, 1'b0, 1'b0);
    // R1 codes 5..7 ignored: cs3 keeps its timing
    wr(2'd3, 5, 9); wr(2'd3, 6, 0); wr(2'd3, 7, 1);
    do_read(2'd3, 24'h0000E2, 1, 2, 1, 2, 4, 1'b0, 1'b0);
    // vector table
    for (int v = 0; v < 8; v++) begin
      cfg_all(VECS[v].cs, VECS[v].rs, VECS[v].rp, VECS[v].ss, VECS[v].sp, VECS[v].cyc);
      do_read(VECS[v].cs, VECS[v].addr, VECS[v].rs, VECS[v].rp, VECS[v].ss, VECS[v].sp,
              VECS[v].cyc, 1'b0, 1'b0);
    end
    // R1 mid-cycle write waits for the next request
    cfg_all(2'd1, 0, 1, 0, 2, 6);
    do_read(2'd1, 24'h101010, 0, 1, 0, 2, 6, 1'b0, 1'b1);
    do_read(2'd1, 24'h202020, 0, 1, 0, 2, 2, 1'b0, 1'b0);
    // R2 requests during busy ignored
    cfg_all(2'd2, 1, 1, 0, 3, 5);
    do_read(2'd2, 24'h314159, 1, 1, 0, 3, 5, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R2", "no late accept", int'(busy), 0);
    finish_up();
  end
endmodule